// File: doc/BRIEF.md
# Link Recovery Trigger Monitor

This block sits beside the link layer of a high-speed serial port and watches the event strobes the link layer produces while the link is active. It raises one recovery-entry request when any of nine fault or timeout conditions is seen, and it reports which condition caused the request as a 4-bit cause code. The conditions cover:

- a training set from the partner;
- acknowledgement and credit sequence numbers that break the expected count;
- header sequence numbers that arrive out of order;
- a full receive header buffer;
- repeated header receive failures;
- ordering breaches before the sequence-number advertisements are exchanged;
- two fixed timeouts, one on outstanding header acknowledgements and one on link-command replies.

The request stays high, and the cause stays frozen, until the recovery state machine pulses `rec_ack`. That pulse clears all internal tracking: expected sequence numbers, failure runs, timers and advertisement flags. Dropping `link_up` also clears the tracking and stops new detections. Timeouts are given in nanoseconds and turned into cycle limits from the clock period parameter.

Top module: `link_recovery_monitor`

## Requirements
- R1: A training-set strobe (`ts1_rx`) while the link is up raises the request with cause 1.
- R2: An acknowledgement whose 2-bit sequence differs from the expected one raises cause 2. The expected value starts at 0 and advances by one on every acknowledgement.
- R3: A credit whose 2-bit sequence differs from the expected one raises cause 3. The expected value starts at 0 and advances by one on every credit.
- R4: A header received without error whose 2-bit sequence differs from the expected one raises cause 4. The expected value starts at 0 and advances on every header received without error.
- R5: A header arrival while `rxbuf_full` is high raises cause 5.
- R6: A third header receive failure in a row raises cause 6. A header received without error resets the run.
- R7: Cause 7 is raised by a received header before the own advertisement is sent (`adv_tx_done`), or by a credit or a low-power request before the partner advertisement arrives (`adv_rx_done`). An advertisement strobe in the same cycle counts as already done.
- R8: When headers are outstanding and no acknowledgement arrives for ACK_TMO_NS/CLK_NS cycles, cause 8 is raised. The request appears on the edge after the limit cycle. Each acknowledgement restarts the timer.
- R9: When a link command gets no reply for CMD_TMO_NS/CLK_NS cycles, cause 9 is raised, with the same timing as R8.
- R10: When several causes fall in one cycle, the lowest cause code is reported.
- R11: The request and cause hold until `rec_ack`. `rec_ack` drops the request, sets the cause to 0 and returns all tracking to its reset values.
- R12: While `link_up` is low no request is raised and all tracking is held cleared.
- R13: After reset the request is low and the cause is 0.
- R14: Sequence numbers wrap modulo 4, so 3 followed by 0 is in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link is in the active state |
| ts1_rx | input | 1 | Training set received from partner |
| ack_vld | input | 1 | Acknowledgement received |
| ack_seq | input | SEQ_W | Acknowledgement sequence number |
| crd_vld | input | 1 | Credit received |
| crd_seq | input | SEQ_W | Credit sequence number |
| hdr_rx_vld | input | 1 | Header packet arrival |
| hdr_rx_seq | input | SEQ_W | Received header sequence number |
| hdr_rx_bad | input | 1 | Header arrival failed its check |
| rxbuf_full | input | 1 | No receive header buffer free |
| hdr_tx | input | 1 | Header packet sent |
| lcmd_tx | input | 1 | Link command sent that awaits a reply |
| lcmd_resp | input | 1 | Link command reply received |
| adv_tx_done | input | 1 | Own sequence advertisement sent |
| adv_rx_done | input | 1 | Partner sequence advertisement received |
| lpm_rx | input | 1 | Low-power entry request received |
| rec_ack | input | 1 | Recovery taken; clears request and tracking |
| rec_req | output | 1 | Recovery-entry request |
| rec_cause | output | 4 | Cause code, 0 when idle |

## Verification
The sequence checks and the ordering and buffer checks can fire in the same cycle. The bench provokes this by driving a training set together with a bad acknowledgement and a bad credit, and then a bad credit together with a header that arrives while the buffer is full. It expects codes 1 and 3. A behavioural reference model compares the request and the cause on every clock, so the holding of a cause while later faults keep arriving is judged as well.

// File: rtl/lrm_pkg.sv
package lrm_pkg;
   localparam int NCAUSE  = 9;
   localparam int CAUSE_W = 4;

   typedef enum logic [CAUSE_W-1:0] {
      CS_NONE      = 4'd0,
      CS_TS1       = 4'd1,
      CS_ACK_SEQ   = 4'd2,
      CS_CRD_SEQ   = 4'd3,
      CS_HDR_ORDER = 4'd4,
      CS_RXBUF     = 4'd5,
      CS_HDR_FAIL  = 4'd6,
      CS_ADV_ORDER = 4'd7,
      CS_ACK_TMO   = 4'd8,
      CS_CMD_TMO   = 4'd9
   } cause_e;
endpackage

// File: rtl/lrm_seq_track.sv
module lrm_seq_track #(
   parameter int SEQ_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hold,
   input  logic             vld,
   input  logic [SEQ_W-1:0] seq,
   output logic             err
);
   if (SEQ_W < 1) begin : g_bad_w
      $error("lrm_seq_track: SEQ_W must be at least 1");
   end

   logic [SEQ_W-1:0] exp_q;

   assign err = vld && (seq != exp_q);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         exp_q <= '0;
      else if (!hold && vld)
         exp_q <= exp_q + 1'b1;
   end

   // R14
   wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !hold && !clr && (exp_q == {SEQ_W{1'b1}})) |=> (exp_q == '0));
endmodule

// File: rtl/lrm_timer.sv
module lrm_timer #(
   parameter int LIM = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic hold,
   input  logic run,
   input  logic restart,
   output logic expired
);
   localparam int CW = $clog2(LIM + 1);

   if (LIM < 2) begin : g_bad_lim
      $error("lrm_timer: LIM must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign expired = run && !restart && (cnt_q == CW'(LIM));

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt_q <= '0;
      else if (!hold) begin
         if (!run || restart)
            cnt_q <= '0;
         else if (cnt_q != CW'(LIM))
            cnt_q <= cnt_q + 1'b1;
      end
   end

   // R8 R9
   restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !hold && !clr) |=> !expired);
endmodule

// File: rtl/lrm_prio.sv
module lrm_prio #(
   parameter int N  = 9,
   parameter int CW = 4
) (
   input  logic [N-1:0]  hits,
   output logic [CW-1:0] code
);
   if (N >= (1 << CW)) begin : g_bad_cw
      $error("lrm_prio: CW too narrow for N causes");
   end

   always_comb begin
      code = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) code = CW'(i + 1);
      end
   end
endmodule

// File: rtl/link_recovery_monitor.sv
module link_recovery_monitor #(
   parameter int SEQ_W       = 2,
   parameter int CLK_NS      = 20,
   parameter int ACK_TMO_NS  = 3000,
   parameter int CMD_TMO_NS  = 1000000,
   parameter int FAIL_LIM    = 3,
   parameter int OUT_W       = 3,
   parameter bit STRICT_ADV  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             link_up,
   input  logic             ts1_rx,
   input  logic             ack_vld,
   input  logic [SEQ_W-1:0] ack_seq,
   input  logic             crd_vld,
   input  logic [SEQ_W-1:0] crd_seq,
   input  logic             hdr_rx_vld,
   input  logic [SEQ_W-1:0] hdr_rx_seq,
   input  logic             hdr_rx_bad,
   input  logic             rxbuf_full,
   input  logic             hdr_tx,
   input  logic             lcmd_tx,
   input  logic             lcmd_resp,
   input  logic             adv_tx_done,
   input  logic             adv_rx_done,
   input  logic             lpm_rx,
   input  logic             rec_ack,
   output logic             rec_req,
   output logic [3:0]       rec_cause
);
   import lrm_pkg::*;

   localparam int ACK_LIM = ACK_TMO_NS / CLK_NS;
   localparam int CMD_LIM = CMD_TMO_NS / CLK_NS;
   localparam int FW      = $clog2(FAIL_LIM + 1);

   if (FAIL_LIM < 2) begin : g_bad_fail
      $error("link_recovery_monitor: FAIL_LIM must be at least 2");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("link_recovery_monitor: CLK_NS must be positive");
   end

   logic               req_q;
   logic [CAUSE_W-1:0] cause_q;
   logic               clr, hold;
   logic               ack_err, crd_err, hdr_err;
   logic               ack_exp, cmd_exp;
   logic [OUT_W-1:0]   out_q;
   logic               pend_q;
   logic               adv_tx_q, adv_rx_q;
   logic               tx_ok, rx_ok;
   logic [FW-1:0]      fail_q;
   logic [NCAUSE-1:0]  hits;
   logic [CAUSE_W-1:0] code;
   logic               hdr_good, hdr_fail, out_dec;

   assign clr      = rec_ack || !link_up;
   assign hold     = req_q;
   assign hdr_good = hdr_rx_vld && !hdr_rx_bad;
   assign hdr_fail = hdr_rx_vld && hdr_rx_bad;
   assign out_dec  = ack_vld && (out_q != '0);

   lrm_seq_track #(.SEQ_W(SEQ_W)) u_ack_seq (
      .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold),
      .vld(ack_vld), .seq(ack_seq), .err(ack_err));

   lrm_seq_track #(.SEQ_W(SEQ_W)) u_crd_seq (
      .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold),
      .vld(crd_vld), .seq(crd_seq), .err(crd_err));

   lrm_seq_track #(.SEQ_W(SEQ_W)) u_hdr_seq (
      .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold),
      .vld(hdr_good), .seq(hdr_rx_seq), .err(hdr_err));

   lrm_timer #(.LIM(ACK_LIM)) u_ack_tmr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold),
      .run(out_q != '0), .restart(ack_vld), .expired(ack_exp));

   lrm_timer #(.LIM(CMD_LIM)) u_cmd_tmr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold),
      .run(pend_q), .restart(lcmd_resp), .expired(cmd_exp));

   if (STRICT_ADV) begin : g_adv_strict
      assign tx_ok = adv_tx_q;
      assign rx_ok = adv_rx_q;
   end else begin : g_adv_lenient
      assign tx_ok = adv_tx_q || adv_tx_done;
      assign rx_ok = adv_rx_q || adv_rx_done;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         out_q    <= '0;
         pend_q   <= 1'b0;
         adv_tx_q <= 1'b0;
         adv_rx_q <= 1'b0;
         fail_q   <= '0;
      end else if (!hold) begin
         if (hdr_tx && !out_dec && (out_q != {OUT_W{1'b1}}))
            out_q <= out_q + 1'b1;
         else if (!hdr_tx && out_dec)
            out_q <= out_q - 1'b1;
         if (lcmd_tx)
            pend_q <= 1'b1;
         else if (lcmd_resp)
            pend_q <= 1'b0;
         if (adv_tx_done) adv_tx_q <= 1'b1;
         if (adv_rx_done) adv_rx_q <= 1'b1;
         if (hdr_good)
            fail_q <= '0;
         else if (hdr_fail && (fail_q != FW'(FAIL_LIM - 1)))
            fail_q <= fail_q + 1'b1;
      end
   end

   always_comb begin
      hits = '0;
      hits[CS_TS1 - 1]       = ts1_rx;
      hits[CS_ACK_SEQ - 1]   = ack_err;
      hits[CS_CRD_SEQ - 1]   = crd_err;
      hits[CS_HDR_ORDER - 1] = hdr_err;
      hits[CS_RXBUF - 1]     = hdr_rx_vld && rxbuf_full;
      hits[CS_HDR_FAIL - 1]  = hdr_fail && (fail_q == FW'(FAIL_LIM - 1));
      hits[CS_ADV_ORDER - 1] = (hdr_rx_vld && !tx_ok) || ((crd_vld || lpm_rx) && !rx_ok);
      hits[CS_ACK_TMO - 1]   = ack_exp;
      hits[CS_CMD_TMO - 1]   = cmd_exp;
   end

   lrm_prio #(.N(NCAUSE), .CW(CAUSE_W)) u_prio (.hits(hits), .code(code));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         cause_q <= CS_NONE;
      end else if (req_q) begin
         if (rec_ack) begin
            req_q   <= 1'b0;
            cause_q <= CS_NONE;
         end
      end else if (link_up && !rec_ack && (code != '0)) begin
         req_q   <= 1'b1;
         cause_q <= code;
      end
   end

   assign rec_req   = req_q;
   assign rec_cause = cause_q;

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_req && !rec_ack) |=> (rec_req && $stable(rec_cause)));

   // R11
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_ack |=> (!rec_req && (rec_cause == 4'd0)));

   // R12
   down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && !rec_req) |=> !rec_req);

   // R1
   ts1_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && ts1_rx && !rec_req && !rec_ack) |=> (rec_req && (rec_cause == 4'd1)));

   // R13
   code_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_req == (rec_cause != 4'd0));
endmodule

// File: tb/link_recovery_monitor_test.sv
module link_recovery_monitor_test;
   localparam int ACK_LIM = 3000 / 20;
   localparam int CMD_LIM = 1000000 / 20;
   localparam int WDOG    = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_up = 1'b0, ts1_rx = 1'b0, ack_vld = 1'b0, crd_vld = 1'b0;
   logic [1:0] ack_seq = '0, crd_seq = '0, hdr_rx_seq = '0;
   logic hdr_rx_vld = 1'b0, hdr_rx_bad = 1'b0, rxbuf_full = 1'b0, hdr_tx = 1'b0;
   logic lcmd_tx = 1'b0, lcmd_resp = 1'b0, adv_tx_done = 1'b0, adv_rx_done = 1'b0;
   logic lpm_rx = 1'b0, rec_ack = 1'b0;
   logic rec_req;
   logic [3:0] rec_cause;

   int compared = 0, mismatched = 0, cycles = 0;
   string cur_req = "R13";
   bit done = 1'b0;

   always #10 clk = ~clk;

   link_recovery_monitor uut (
      .clk(clk), .rst_n(rst_n), .link_up(link_up), .ts1_rx(ts1_rx),
      .ack_vld(ack_vld), .ack_seq(ack_seq), .crd_vld(crd_vld), .crd_seq(crd_seq),
      .hdr_rx_vld(hdr_rx_vld), .hdr_rx_seq(hdr_rx_seq), .hdr_rx_bad(hdr_rx_bad),
      .rxbuf_full(rxbuf_full), .hdr_tx(hdr_tx), .lcmd_tx(lcmd_tx),
      .lcmd_resp(lcmd_resp), .adv_tx_done(adv_tx_done), .adv_rx_done(adv_rx_done),
      .lpm_rx(lpm_rx), .rec_ack(rec_ack), .rec_req(rec_req), .rec_cause(rec_cause));

   // behavioural reference model
   int m_req = 0, m_cause = 0;
   int eack = 0, ecrd = 0, ehdr = 0, fails = 0, outn = 0, acnt = 0, lcnt = 0;
   bit pend = 0, atx = 0, arx = 0;

   task automatic m_clear();
      eack = 0; ecrd = 0; ehdr = 0; fails = 0; outn = 0; acnt = 0; lcnt = 0;
      pend = 0; atx = 0; arx = 0;
   endtask

   always @(posedge clk) begin
      int code;
      int was;
      if (!rst_n) begin
         m_req = 0; m_cause = 0; m_clear();
      end else begin
         was = m_req;
         code = 0;
         if (ts1_rx) code = 1;
         else if (ack_vld && int'(ack_seq) != eack) code = 2;
         else if (crd_vld && int'(crd_seq) != ecrd) code = 3;
         else if (hdr_rx_vld && !hdr_rx_bad && int'(hdr_rx_seq) != ehdr) code = 4;
         else if (hdr_rx_vld && rxbuf_full) code = 5;
         else if (hdr_rx_vld && hdr_rx_bad && fails == 2) code = 6;
         else if ((hdr_rx_vld && !(atx || adv_tx_done)) ||
                  ((crd_vld || lpm_rx) && !(arx || adv_rx_done))) code = 7;
         else if (outn > 0 && acnt == ACK_LIM && !ack_vld) code = 8;
         else if (pend && lcnt == CMD_LIM && !lcmd_resp) code = 9;

         if (m_req != 0) begin
            if (rec_ack) begin m_req = 0; m_cause = 0; end
         end else if (link_up && !rec_ack && code != 0) begin
            m_req = 1; m_cause = code;
         end

         if (rec_ack || !link_up) m_clear();
         else if (was == 0) begin
            if (ack_vld) eack = (eack + 1) % 4;
            if (crd_vld) ecrd = (ecrd + 1) % 4;
            if (hdr_rx_vld) begin
               if (hdr_rx_bad) begin
                  if (fails < 2) fails++;
               end else begin
                  fails = 0; ehdr = (ehdr + 1) % 4;
               end
            end
            acnt = (outn == 0 || ack_vld) ? 0 : ((acnt < ACK_LIM) ? acnt + 1 : acnt);
            if (hdr_tx && !(ack_vld && outn > 0)) outn++;
            else if (!hdr_tx && ack_vld && outn > 0) outn--;
            lcnt = (!pend || lcmd_resp) ? 0 : ((lcnt < CMD_LIM) ? lcnt + 1 : lcnt);
            if (lcmd_tx) pend = 1; else if (lcmd_resp) pend = 0;
            if (adv_tx_done) atx = 1;
            if (adv_rx_done) arx = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         compared++;
         if (int'(rec_req) != m_req || int'(rec_cause) != m_cause) begin
            mismatched++;
            $display("FAIL %s model: req=%0d cause=%0d expected req=%0d cause=%0d",
                     cur_req, rec_req, rec_cause, m_req, m_cause);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == WDOG && !done) begin
         done = 1'b1;
         mismatched++;
         $display("FAIL %s watchdog: cycles=%0d expected below %0d", cur_req, cycles, WDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle_ins();
      ts1_rx = 0; ack_vld = 0; crd_vld = 0; hdr_rx_vld = 0; hdr_rx_bad = 0;
      rxbuf_full = 0; hdr_tx = 0; lcmd_tx = 0; lcmd_resp = 0;
      adv_tx_done = 0; adv_rx_done = 0; lpm_rx = 0; rec_ack = 0;
   endtask

   task automatic expect_o(input string tag, input int req, input int cause);
      compared++;
      if (int'(rec_req) != req || int'(rec_cause) != cause) begin
         mismatched++;
         $display("FAIL %s: req=%0d cause=%0d expected req=%0d cause=%0d",
                  tag, rec_req, rec_cause, req, cause);
      end
   endtask

   task automatic do_adv();
      adv_tx_done = 1; adv_rx_done = 1; tick(); idle_ins();
   endtask

   task automatic do_ack();
      rec_ack = 1; tick(); rec_ack = 0; tick();
   endtask

   task automatic hdr_in(input int s, input bit bad);
      hdr_rx_vld = 1; hdr_rx_seq = 2'(s); hdr_rx_bad = bad; tick(); idle_ins();
   endtask

   initial begin
      idle_ins();
      repeat (3) tick();
      expect_o("R13", 0, 0);
      rst_n = 1; link_up = 1;
      tick();
      expect_o("R13", 0, 0);

      // R1
      cur_req = "R1";
      do_adv();
      ts1_rx = 1; tick(); idle_ins();
      expect_o("R1", 1, 1);
      do_ack();
      expect_o("R11", 0, 0);

      // R2 with R14 wrap
      cur_req = "R2";
      do_adv();
      for (int s = 0; s < 5; s++) begin
         ack_vld = 1; ack_seq = 2'(s % 4); tick(); idle_ins();
         expect_o("R14", 0, 0);
      end
      ack_vld = 1; ack_seq = 2'd2; tick(); idle_ins();
      expect_o("R2", 1, 2);
      do_ack();

      // R3
      cur_req = "R3";
      do_adv();
      for (int s = 0; s < 6; s++) begin
         crd_vld = 1; crd_seq = 2'(s % 4); tick(); idle_ins();
      end
      expect_o("R14", 0, 0);
      crd_vld = 1; crd_seq = 2'd3; tick(); idle_ins();
      expect_o("R3", 1, 3);
      do_ack();

      // R4
      cur_req = "R4";
      do_adv();
      hdr_in(0, 0); hdr_in(1, 0);
      expect_o("R4", 0, 0);
      hdr_in(3, 0);
      expect_o("R4", 1, 4);
      do_ack();

      // R5
      cur_req = "R5";
      do_adv();
      rxbuf_full = 1; hdr_in(0, 0);
      expect_o("R5", 1, 5);
      do_ack();

      // R6
      cur_req = "R6";
      do_adv();
      hdr_in(0, 1); hdr_in(0, 1); hdr_in(0, 0); hdr_in(1, 1); hdr_in(1, 1);
      expect_o("R6", 0, 0);
      hdr_in(1, 1);
      expect_o("R6", 1, 6);
      do_ack();

      // R7
      cur_req = "R7";
      hdr_in(0, 0);
      expect_o("R7", 1, 7);
      do_ack();
      adv_tx_done = 1; tick(); idle_ins();
      crd_vld = 1; crd_seq = 0; tick(); idle_ins();
      expect_o("R7", 1, 7);
      do_ack();
      adv_tx_done = 1; tick(); idle_ins();
      lpm_rx = 1; tick(); idle_ins();
      expect_o("R7", 1, 7);
      do_ack();
      adv_tx_done = 1; adv_rx_done = 1; hdr_in(0, 0);
      expect_o("R7", 0, 0);
      do_ack();

      // R8
      cur_req = "R8";
      do_adv();
      hdr_tx = 1; tick(); idle_ins();
      repeat (100) tick();
      ack_vld = 1; ack_seq = 0; tick(); idle_ins();
      repeat (ACK_LIM + 10) tick();
      expect_o("R8", 0, 0);
      hdr_tx = 1; tick(); idle_ins();
      repeat (ACK_LIM) tick();
      expect_o("R8", 0, 0);
      tick();
      expect_o("R8", 1, 8);
      do_ack();

      // R9
      cur_req = "R9";
      do_adv();
      lcmd_tx = 1; tick(); idle_ins();
      repeat (CMD_LIM - 5) tick();
      lcmd_resp = 1; tick(); idle_ins();
      repeat (20) tick();
      expect_o("R9", 0, 0);
      lcmd_tx = 1; tick(); idle_ins();
      repeat (CMD_LIM) tick();
      expect_o("R9", 0, 0);
      tick();
      expect_o("R9", 1, 9);
      do_ack();

      // R10
      cur_req = "R10";
      do_adv();
      ts1_rx = 1; ack_vld = 1; ack_seq = 3; crd_vld = 1; crd_seq = 2; tick(); idle_ins();
      expect_o("R10", 1, 1);
      do_ack();
      do_adv();
      crd_vld = 1; crd_seq = 1; rxbuf_full = 1; hdr_in(0, 0);
      expect_o("R10", 1, 3);

      // R11
      cur_req = "R11";
      for (int k = 0; k < 5; k++) begin
         ts1_rx = 1; ack_vld = 1; ack_seq = 2'(k); tick(); idle_ins();
         expect_o("R11", 1, 3);
      end
      do_ack();
      expect_o("R11", 0, 0);
      do_adv();
      ack_vld = 1; ack_seq = 0; crd_vld = 1; crd_seq = 0; hdr_in(0, 0);
      expect_o("R11", 0, 0);

      // R12
      cur_req = "R12";
      link_up = 0;
      ts1_rx = 1; ack_vld = 1; ack_seq = 3; tick(); idle_ins();
      repeat (3) tick();
      expect_o("R12", 0, 0);
      link_up = 1; tick();
      hdr_in(0, 0);
      expect_o("R12", 1, 7);
      do_ack();
      expect_o("R12", 0, 0);

      repeat (3) tick();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule